// File: doc/BRIEF.md
# Reference Edge Doubler and Programmable R Divider

This block derives the phase-detector reference tick from an asynchronous reference input. The reference is brought into the system clock domain through a flop chain, and its level changes are turned into single-cycle edge events. A doubler control bit selects which of those events count. With the bit clear, only high-to-low transitions are active. With the bit set, transitions in both directions are active, so the event rate into the divider is twice the reference frequency.

A 4-bit R divider then emits one pulse, one clock wide, on every R-th active event. Software writes R as a plain value from 1 to 15, and the code 0 behaves as divide-by-1. A new R does not cut the current division period short: it is picked up at the first active event of the next period.

Two controls put the divider into its load state: a counter-reset input and a power-down input. While either is high, the divider holds its count at zero and gives no output. When the last of them is released, counting starts again from a fresh period.

Top module: `refDivTop`

## Requirements
- R1: While the reset input rstN is low, and on the first cycle after its release, pfdTick is low and the divider is at the start of a period.
- R2: With dblEn at 0, only falling transitions of refIn (1 to 0) are active events. Rising transitions do not advance the divider.
- R3: With dblEn at 1, both rising and falling transitions of refIn are active events.
- R4: pfdTick is high for exactly one clock cycle on every R-th active event, where R is the divide value in force. It is low at all other times.
- R5: An rDiv value of 0 divides by 1, so every active event produces a pulse.
- R6: An rDiv value of 15, the largest the 4-bit field holds, produces one pulse per 15 active events.
- R7: While cntRst is 1, the divider stays at count zero, active events are ignored and pfdTick stays low. After release, the next pulse comes R active events later.
- R8: While pwrDown is 1, the divider behaves exactly as under R7.
- R9: rDiv is sampled only at the first active event of each period, so a change made in the middle of a period takes effect from the next period.
- R10: For a refIn transition that counts as active and completes a period, pfdTick is high in the cycle after the third rising clock edge following the refIn change. The synchronizer's first stage captures the change at the first of those edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refIn | input | 1 | Reference signal, asynchronous to clk |
| dblEn | input | 1 | 1 makes both transitions active; 0 makes only falling transitions active |
| rDiv | input | 4 | Divide ratio 1..15; 0 acts as 1 |
| cntRst | input | 1 | Holds the divider in its load state |
| pwrDown | input | 1 | Power-down; holds the divider in its load state |
| pfdTick | output | 1 | One-cycle phase-detector reference pulse |

## Verification
The bench builds the block with its defaults: a two-flop synchronizer and a 4-bit divide field. These defaults make every divide code reachable, including 0 as the degenerate case and 15 as the longest period. With the synchronizer depth fixed, each expected pulse can be predicted to the exact cycle rather than to a window. That exact prediction checks the latency, the doubler's edge selection, the deferred pickup of a new R, and pulse suppression in both load-state controls.

// File: rtl/refDivPkg.sv
package refDivPkg;

  // Strobes passed from edge control to the divider datapath
  typedef struct packed {
    logic evt;   // one active reference event this cycle
    logic hold;  // divider forced to its load state
  } divStrobeT;

endpackage

// File: rtl/refSync.sv
module refSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= 1'b0;
          else       chain[0] <= dIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dOut = chain[STAGES-1];

endmodule

// File: rtl/refEdgeCtrl.sv
module refEdgeCtrl
  import refDivPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      refIn,
  input  logic      dblEn,
  input  logic      cntRst,
  input  logic      pwrDown,
  output divStrobeT strobe
);

  logic refLvl;
  logic prevLvl;
  logic riseSeen;
  logic fallSeen;

  refSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (refIn),
    .dOut (refLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= refLvl;
  end

  assign riseSeen = refLvl & ~prevLvl;
  assign fallSeen = ~refLvl & prevLvl;

  always_comb begin
    strobe.hold = cntRst | pwrDown;
    if (dblEn) strobe.evt = riseSeen | fallSeen;
    else       strobe.evt = fallSeen;
  end

  AST_EVT_NEEDS_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evt |-> (refLvl != $past(refLvl))); // R3
  AST_SINGLE_FALL_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evt && !dblEn) |-> !refLvl); // R2

endmodule

// File: rtl/refDivPath.sv
module refDivPath
  import refDivPkg::*;
#(
  parameter int R_WIDTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobeT          strobe,
  input  logic [R_WIDTH-1:0] rDiv,
  output logic               tick
);

  localparam logic [R_WIDTH-1:0] ONE = R_WIDTH'(1);

  logic [R_WIDTH-1:0] cnt;
  logic [R_WIDTH-1:0] divHeld;
  logic [R_WIDTH-1:0] divEff;
  logic [R_WIDTH-1:0] divNow;
  logic [R_WIDTH-1:0] cntNext;
  logic               wrap;

  assign divEff  = (rDiv == '0) ? ONE : rDiv;
  assign divNow  = (cnt == '0) ? divEff : divHeld;
  assign cntNext = cnt + ONE;
  assign wrap    = (cntNext == divNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      divHeld <= ONE;
      tick    <= 1'b0;
    end else if (strobe.hold) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= strobe.evt & wrap;
      if (strobe.evt) begin
        if (cnt == '0) divHeld <= divEff;
        cnt <= wrap ? '0 : cntNext;
      end
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> !tick); // R7
  AST_HOLD_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (cnt == '0)); // R8
  AST_CNT_BELOW_DIV: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> (cnt < divHeld)); // R4
  AST_DIV_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |=> $stable(divHeld)); // R9
  AST_TICK_FROM_EVT: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> ($past(strobe.evt) && !$past(strobe.hold))); // R10

endmodule

// File: rtl/refDivTop.sv
module refDivTop
  import refDivPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int R_WIDTH     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refIn,
  input  logic               dblEn,
  input  logic [R_WIDTH-1:0] rDiv,
  input  logic               cntRst,
  input  logic               pwrDown,
  output logic               pfdTick
);

  divStrobeT strobe;

  refEdgeCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .refIn   (refIn),
    .dblEn   (dblEn),
    .cntRst  (cntRst),
    .pwrDown (pwrDown),
    .strobe  (strobe)
  );

  refDivPath #(.R_WIDTH(R_WIDTH)) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rDiv   (rDiv),
    .tick   (pfdTick)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> !pfdTick); // R1

endmodule

// File: tb/refDivTop_test.sv
module refDivTop_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refIn = 1'b0;
  logic       dblEn = 1'b0;
  logic [3:0] rDiv = 4'd1;
  logic       cntRst = 1'b0;
  logic       pwrDown = 1'b0;
  logic       pfdTick;

  int    cycCnt = 0;
  int    nChecks = 0;
  int    nFails = 0;
  int    mdlCnt = 0;
  int    mdlDiv = 1;
  string curTag = "R1";
  int    expCyc[$];
  string expTag[$];
  bit    done = 1'b0;

  refDivTop uut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .dblEn(dblEn),
    .rDiv(rDiv), .cntRst(cntRst), .pwrDown(pwrDown), .pfdTick(pfdTick)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  task automatic check(string tag, bit ok, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: compare produced pulses against the expected queue
  always @(negedge clk) begin
    if (rstN && !done) begin
      while (expCyc.size() > 0 && expCyc[0] < cycCnt) begin
        check(expTag[0], 1'b0, 0, expCyc[0]);
        void'(expCyc.pop_front());
        void'(expTag.pop_front());
      end
      if (pfdTick) begin
        if (expCyc.size() > 0 && expCyc[0] == cycCnt) begin
          check(expTag[0], 1'b1, cycCnt, expCyc[0]);
          void'(expCyc.pop_front());
          void'(expTag.pop_front());
        end else begin
          check(curTag, 1'b0, cycCnt, -1);
        end
      end
    end
  end

  // Driver: toggle the reference and predict the pulse
  task automatic toggleRef(string tag);
    int n;
    bit isFall;
    bit holdOn;
    @(negedge clk);
    curTag = tag;
    refIn  = ~refIn;
    n      = cycCnt;
    isFall = (refIn == 1'b0);
    holdOn = cntRst | pwrDown;
    if (!holdOn && (dblEn || isFall)) begin
      if (mdlCnt == 0) mdlDiv = (rDiv == 4'd0) ? 1 : int'(rDiv);
      mdlCnt++;
      if (mdlCnt == mdlDiv) begin
        expCyc.push_back(n + 3);
        expTag.push_back(tag);
        mdlCnt = 0;
      end
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic toggles(string tag, int cnt);
    for (int i = 0; i < cnt; i++) toggleRef(tag);
  endtask

  task automatic setCfg(bit dbl, logic [3:0] r);
    @(negedge clk);
    dblEn = dbl;
    rDiv  = r;
    repeat (2) @(negedge clk);
  endtask

  task automatic setHold(bit useRst, bit v);
    @(negedge clk);
    if (useRst) cntRst = v;
    else        pwrDown = v;
    mdlCnt = 0;
    repeat (5) @(negedge clk);
  endtask

  task automatic drain(string tag);
    repeat (8) @(negedge clk);
    check(tag, expCyc.size() == 0, expCyc.size(), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    done = 1'b1;
    check("watchdog", 1'b0, cycCnt, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : stimulus
    // R1: quiet in and right after reset
    repeat (3) @(negedge clk);
    check("R1", pfdTick == 1'b0, pfdTick, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", pfdTick == 1'b0, pfdTick, 0);

    // R2 / R4: single edge, divide by 3
    setCfg(1'b0, 4'd3);
    toggles("R2", 12);
    drain("R2");

    // R3: both edges, divide by 3
    setCfg(1'b1, 4'd3);
    toggles("R3", 12);
    drain("R3");

    // R5: code 0 divides by 1
    setCfg(1'b0, 4'd0);
    toggles("R5", 6);
    setCfg(1'b1, 4'd0);
    toggles("R5", 4);
    drain("R5");

    // R6: longest period
    setCfg(1'b1, 4'd15);
    toggles("R6", 30);
    drain("R6");

    // R9: change mid-period
    setCfg(1'b1, 4'd4);
    toggles("R9", 2);
    setCfg(1'b1, 4'd2);
    toggles("R9", 6);
    drain("R9");

    // R7: counter reset hold
    setCfg(1'b1, 4'd3);
    toggles("R7", 2);
    setHold(1'b1, 1'b1);
    toggles("R7", 5);
    setHold(1'b1, 1'b0);
    toggles("R7", 6);
    drain("R7");

    // R8: power-down hold
    setCfg(1'b0, 4'd2);
    toggles("R8", 3);
    setHold(1'b0, 1'b1);
    toggles("R8", 6);
    setHold(1'b0, 1'b0);
    toggles("R8", 8);
    drain("R8");

    // R10: exact latency at divide by 1 and 2
    setCfg(1'b1, 4'd1);
    toggles("R10", 3);
    setCfg(1'b0, 4'd2);
    toggles("R10", 8);
    drain("R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule